// File: doc/BRIEF.md
# Physical-Layer Remote Command Responder

This block sits beside a physical-layer node and serves remote command packets sent to it by other nodes. A packet arrives as two 32-bit quadlets on a one-cycle strobe. The second quadlet must be the bitwise complement of the first. The first quadlet names a destination node, a port number and a three-bit command. When the packet is addressed to this node and carries the command type, the block does two things. It drives a one-cycle action pulse toward the addressed port, and it then returns a two-quadlet confirmation packet.

The confirmation reports four things. It gives the live fault, connected, bias and disabled bits of the addressed port, sampled after the action has taken effect. It gives an accept flag. It echoes the command code and the port. It carries the local node number as the sender. The confirmation is held on a valid/ready output until it is taken. The block accepts one command at a time, and packets that arrive while it is busy are discarded.

First-quadlet layout, shared by command and confirmation:

| Bits | Contents |
|------|----------|
| [31:30] | zero |
| [29:24] | node number |
| [23:22] | zero |
| [21:18] | packet type |
| [17:15] | zero |
| [14:11] | port |
| [10:8] | zero |
| [7:4] | status f,c,b,d |
| [3] | accept |
| [2:0] | command |

Top module: `rcmd_responder`

## Requirements
- R1: A confirmation carries type 0xA in bits [21:18] and the local node number in bits [29:24]. Its bits [31:30], [23:22], [17:15] and [10:8] are zero. Its second quadlet is the bitwise complement of its first.
- R2: A received packet is dropped without any pulse or confirmation in three cases: its second quadlet is not the complement of its first, its bits [29:24] differ from the local node number, or its bits [21:18] are not 8.
- R3: An accepted command drives exactly one one-cycle pulse, in the cycle after the strobe, on the output bit indexed by the port. The output for each code is: code 2 to the suspend output, code 4 to the fault-clear output, code 5 to the enable output, and code 6 to the resume output.
- R4: Code 1 drives the notify output in the cycle after the strobe and the disable output of the same port in the following cycle.
- R5: A port number of 3 or above produces a confirmation with accept bit [3] = 0, status bits [7:4] = 0 and no action pulse.
- R6: Codes 3 and 7 produce a confirmation with accept = 0 and no pulse. Code 0 produces accept = 1 and no pulse.
- R7: Bits [7:4] hold the addressed port's fault, connected, bias and disabled bits, with fault in bit 7. They are sampled one cycle after the last action pulse, and the confirmation becomes valid in the next cycle.
- R8: The confirmation stays valid and unchanged until ready is high. A packet received while a command is in progress or a confirmation is pending is ignored.
- R9: The confirmation echoes the received command code in bits [2:0] and the received port number in bits [14:11].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rx_valid | input | 1 | One-cycle strobe for a received packet |
| rx_q0 | input | 32 | Received first quadlet |
| rx_q1 | input | 32 | Received second quadlet |
| local_id | input | 6 | Local node number |
| port_fault | input | NPORT | Per-port fault status |
| port_conn | input | NPORT | Per-port connected status |
| port_bias | input | NPORT | Per-port bias status |
| port_dis | input | NPORT | Per-port disabled status |
| act_notify | output | NPORT | Pulse: send disable notification |
| act_disable | output | NPORT | Pulse: disable port |
| act_suspend | output | NPORT | Pulse: start suspend |
| act_clear_fault | output | NPORT | Pulse: clear fault bit |
| act_enable | output | NPORT | Pulse: enable port |
| act_resume | output | NPORT | Pulse: resume port |
| cf_valid | output | 1 | Confirmation present |
| cf_ready | input | 1 | Consumer takes the confirmation |
| cf_q0 | output | 32 | Confirmation first quadlet |
| cf_q1 | output | 32 | Confirmation second quadlet |

## Verification
Every command code is sent to several ports, and each case is checked for which pulse fires, on which port bit and in which cycle. This separates an accepted action from a reserved code or an out-of-range port, and it separates the two-step disable sequence from a single pulse. A model of the port status reacts to the pulses, so a confirmation whose status bits show the fault cleared or the disable bit changed proves that sampling happened after the action rather than at receipt. Malformed packets, each with exactly one defect (bad complement, foreign node number, wrong type), show that each drop condition works on its own. A second packet sent while ready is held low tells whether the hold and the busy rule hold up.

// File: rtl/rcmd_pkg.sv
package rcmd_pkg;
  localparam int QW       = 32;
  localparam int IDW      = 6;
  localparam int PFW      = 4;
  localparam int ID_LSB   = 24;
  localparam int TYPE_LSB = 18;
  localparam int PORT_LSB = 11;
  localparam int STAT_LSB = 4;
  localparam int OK_BIT   = 3;
  localparam logic [3:0] TYPE_REQ = 4'h8;
  localparam logic [3:0] TYPE_RSP = 4'hA;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_DISABLE = 3'd1,
    CMD_SUSPEND = 3'd2,
    CMD_RSV3    = 3'd3,
    CMD_CLRFLT  = 3'd4,
    CMD_ENABLE  = 3'd5,
    CMD_RESUME  = 3'd6,
    CMD_RSV7    = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FIRE   = 3'd1,
    ST_FIRE2  = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_HOLD   = 3'd4
  } st_e;

  typedef struct packed {
    logic [PFW-1:0] port;
    cmd_e           cmd;
    logic           ok;
  } req_t;
endpackage

// File: rtl/rcmd_check.sv
// Combinational screening and field extraction of a received packet.
module rcmd_check
  import rcmd_pkg::*;
#(
  parameter int NPORT = 3
) (
  input  logic [QW-1:0]  q0,
  input  logic [QW-1:0]  q1,
  input  logic [IDW-1:0] local_id,
  output logic           take,
  output req_t           req
);
  localparam logic [PFW-1:0] PORT_LIM = PFW'(NPORT);

  logic inv_ok, id_ok, type_ok, port_ok, cmd_ok;

  always_comb begin
    inv_ok   = (q1 == ~q0);
    id_ok    = (q0[ID_LSB +: IDW] == local_id);
    type_ok  = (q0[TYPE_LSB +: 4] == TYPE_REQ);
    take     = inv_ok && id_ok && type_ok;
    req.port = q0[PORT_LSB +: PFW];
    req.cmd  = cmd_e'(q0[2:0]);
    port_ok  = (req.port < PORT_LIM);
    cmd_ok   = (req.cmd != CMD_RSV3) && (req.cmd != CMD_RSV7);
    req.ok   = port_ok && cmd_ok;
  end
endmodule

// File: rtl/rcmd_ctrl.sv
// Sequencer: latches one command, fires its pulses, then waits for handshake.
module rcmd_ctrl
  import rcmd_pkg::*;
#(
  parameter int NPORT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             take,
  input  req_t             req_in,
  input  logic             cf_done,
  output req_t             req_q,
  output logic             sample_en,
  output logic [NPORT-1:0] act_notify,
  output logic [NPORT-1:0] act_disable,
  output logic [NPORT-1:0] act_suspend,
  output logic [NPORT-1:0] act_clear_fault,
  output logic [NPORT-1:0] act_enable,
  output logic [NPORT-1:0] act_resume
);
  st_e  st_q, st_d;
  logic load;

  assign load = (st_q == ST_IDLE) && rx_valid && take;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (load) st_d = ST_FIRE;
      ST_FIRE:   st_d = (req_q.ok && req_q.cmd == CMD_DISABLE) ? ST_FIRE2 : ST_SAMPLE;
      ST_FIRE2:  st_d = ST_SAMPLE;
      ST_SAMPLE: st_d = ST_HOLD;
      ST_HOLD:   if (cf_done) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= '0;
    end else begin
      st_q <= st_d;
      if (load) req_q <= req_in;
    end
  end

  assign sample_en = (st_q == ST_SAMPLE);

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic hit, fire;
    assign hit  = req_q.ok && (req_q.port == PFW'(i));
    assign fire = hit && (st_q == ST_FIRE);
    assign act_notify[i]      = fire && (req_q.cmd == CMD_DISABLE);
    assign act_disable[i]     = hit && (st_q == ST_FIRE2);
    assign act_suspend[i]     = fire && (req_q.cmd == CMD_SUSPEND);
    assign act_clear_fault[i] = fire && (req_q.cmd == CMD_CLRFLT);
    assign act_enable[i]      = fire && (req_q.cmd == CMD_ENABLE);
    assign act_resume[i]      = fire && (req_q.cmd == CMD_RESUME);
  end
endmodule

// File: rtl/rcmd_confirm.sv
// Builds and holds the confirmation packet.
module rcmd_confirm
  import rcmd_pkg::*;
#(
  parameter int NPORT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  req_t             req_q,
  input  logic [IDW-1:0]   local_id,
  input  logic [NPORT-1:0] port_fault,
  input  logic [NPORT-1:0] port_conn,
  input  logic [NPORT-1:0] port_bias,
  input  logic [NPORT-1:0] port_dis,
  input  logic             cf_ready,
  output logic             cf_valid,
  output logic             cf_done,
  output logic [QW-1:0]    cf_q0,
  output logic [QW-1:0]    cf_q1
);
  logic [3:0]    stat_sel;
  logic [QW-1:0] q0_d;
  logic          valid_d;

  always_comb begin
    stat_sel = 4'b0000;
    for (int i = 0; i < NPORT; i++) begin
      if (req_q.port == PFW'(i))
        stat_sel = {port_fault[i], port_conn[i], port_bias[i], port_dis[i]};
    end
    q0_d                    = '0;
    q0_d[ID_LSB +: IDW]     = local_id;
    q0_d[TYPE_LSB +: 4]     = TYPE_RSP;
    q0_d[PORT_LSB +: PFW]   = req_q.port;
    q0_d[STAT_LSB +: 4]     = stat_sel;
    q0_d[OK_BIT]            = req_q.ok;
    q0_d[2:0]               = req_q.cmd;
  end

  assign cf_done = cf_valid && cf_ready;

  always_comb begin
    valid_d = cf_valid;
    if (sample_en)    valid_d = 1'b1;
    else if (cf_done) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_valid <= 1'b0;
      cf_q0    <= '0;
      cf_q1    <= '0;
    end else begin
      cf_valid <= valid_d;
      if (sample_en) begin
        cf_q0 <= q0_d;
        cf_q1 <= ~q0_d;
      end
    end
  end
endmodule

// File: rtl/rcmd_responder.sv
module rcmd_responder
  import rcmd_pkg::*;
#(
  parameter int NPORT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [31:0]      rx_q0,
  input  logic [31:0]      rx_q1,
  input  logic [5:0]       local_id,
  input  logic [NPORT-1:0] port_fault,
  input  logic [NPORT-1:0] port_conn,
  input  logic [NPORT-1:0] port_bias,
  input  logic [NPORT-1:0] port_dis,
  output logic [NPORT-1:0] act_notify,
  output logic [NPORT-1:0] act_disable,
  output logic [NPORT-1:0] act_suspend,
  output logic [NPORT-1:0] act_clear_fault,
  output logic [NPORT-1:0] act_enable,
  output logic [NPORT-1:0] act_resume,
  output logic             cf_valid,
  input  logic             cf_ready,
  output logic [31:0]      cf_q0,
  output logic [31:0]      cf_q1
);
  logic take, sample_en, cf_done;
  req_t req_in, req_q;

  rcmd_check #(.NPORT(NPORT)) check_i (
    .q0(rx_q0), .q1(rx_q1), .local_id(local_id),
    .take(take), .req(req_in)
  );

  rcmd_ctrl #(.NPORT(NPORT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .take(take),
    .req_in(req_in), .cf_done(cf_done), .req_q(req_q), .sample_en(sample_en),
    .act_notify(act_notify), .act_disable(act_disable),
    .act_suspend(act_suspend), .act_clear_fault(act_clear_fault),
    .act_enable(act_enable), .act_resume(act_resume)
  );

  rcmd_confirm #(.NPORT(NPORT)) confirm_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .req_q(req_q),
    .local_id(local_id), .port_fault(port_fault), .port_conn(port_conn),
    .port_bias(port_bias), .port_dis(port_dis), .cf_ready(cf_ready),
    .cf_valid(cf_valid), .cf_done(cf_done), .cf_q0(cf_q0), .cf_q1(cf_q1)
  );
endmodule

// File: rtl/rcmd_responder_chk.sv
module rcmd_responder_chk
  import rcmd_pkg::*;
#(
  parameter int NPORT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] act_notify,
  input logic [NPORT-1:0] act_disable,
  input logic [NPORT-1:0] act_suspend,
  input logic [NPORT-1:0] act_clear_fault,
  input logic [NPORT-1:0] act_enable,
  input logic [NPORT-1:0] act_resume,
  input logic             cf_valid,
  input logic             cf_ready,
  input logic [31:0]      cf_q0,
  input logic [31:0]      cf_q1
);
  logic [6*NPORT-1:0] acts;
  assign acts = {act_resume, act_enable, act_clear_fault,
                 act_suspend, act_disable, act_notify};

  a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acts));

  a_r4_disable_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_notify) |=> (act_disable == $past(act_notify)));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_valid && !cf_ready) |=> (cf_valid && $stable(cf_q0) && $stable(cf_q1)));

  a_r8_no_pulse_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid |-> (acts == '0));

  a_r1_header: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid |-> (cf_q0[TYPE_LSB +: 4] == TYPE_RSP && cf_q0[31:30] == 2'b00));

  a_r5_port_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_valid && cf_q0[PORT_LSB +: PFW] >= PFW'(NPORT))
      |-> (!cf_q0[OK_BIT] && cf_q0[STAT_LSB +: 4] == 4'b0000));

  a_r6_reserved_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_valid && (cf_q0[2:0] == 3'd3 || cf_q0[2:0] == 3'd7)) |-> !cf_q0[OK_BIT]);
endmodule

bind rcmd_responder rcmd_responder_chk #(.NPORT(NPORT)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .act_notify(act_notify), .act_disable(act_disable),
  .act_suspend(act_suspend), .act_clear_fault(act_clear_fault),
  .act_enable(act_enable), .act_resume(act_resume),
  .cf_valid(cf_valid), .cf_ready(cf_ready), .cf_q0(cf_q0), .cf_q1(cf_q1)
);

// File: tb/rcmd_responder_tb.sv
module rcmd_responder_tb_top;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic          rx_valid;
  logic [31:0]   rx_q0, rx_q1;
  logic [5:0]    lid;
  logic [NP-1:0] st_f, st_c, st_b, st_d;
  logic [NP-1:0] act_notify, act_disable, act_suspend, act_clear_fault, act_enable, act_resume;
  logic          cf_valid, cf_ready;
  logic [31:0]   cf_q0, cf_q1;
  logic [17:0]   acts;
  assign acts = {act_resume, act_enable, act_clear_fault, act_suspend, act_disable, act_notify};

  rcmd_responder #(.NPORT(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_q0(rx_q0), .rx_q1(rx_q1),
    .local_id(lid), .port_fault(st_f), .port_conn(st_c), .port_bias(st_b), .port_dis(st_d),
    .act_notify(act_notify), .act_disable(act_disable), .act_suspend(act_suspend),
    .act_clear_fault(act_clear_fault), .act_enable(act_enable), .act_resume(act_resume),
    .cf_valid(cf_valid), .cf_ready(cf_ready), .cf_q0(cf_q0), .cf_q1(cf_q1)
  );

  // Port status model reacting to the action pulses.
  always @(posedge clk) begin
    if (rst_n) begin
      st_f <= st_f & ~act_clear_fault;
      st_d <= (st_d | act_disable) & ~act_enable;
    end
  end

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [31:0] expq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkq(input logic [5:0] id, input logic [3:0] ty,
                                      input logic [3:0] p, input logic [3:0] s,
                                      input logic ok, input logic [2:0] c);
    return {2'b00, id, 2'b00, ty, 3'b000, p, 3'b000, s, ok, c};
  endfunction

  // Monitor: pops the scoreboard on every completed handshake.
  always @(negedge clk) begin
    if (rst_n && cf_valid && cf_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8 unexpected confirmation", 64'(cf_q0), 64'h0);
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(cf_q0 == e, "R1 R7 R9 confirmation quadlet", 64'(cf_q0), 64'(e));
        chk(cf_q1 == ~e, "R1 complement quadlet", 64'(cf_q1), 64'(~e));
      end
    end
  end

  task automatic drive(input logic [31:0] q0, input logic [31:0] q1);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_q0    = q0;
    rx_q1    = q1;
  endtask

  // Predicts the confirmation and the pulses, then checks them cycle by cycle.
  task automatic send(input logic [3:0] p, input logic [2:0] c);
    logic ok;
    logic [3:0] s;
    logic [17:0] ep, ep2;
    logic [NP-1:0] f, d;
    int pi;
    pi = int'(p);
    ok = (pi < NP) && (c != 3'd3) && (c != 3'd7);
    f = st_f; d = st_d; ep = '0; ep2 = '0;
    if (ok) begin
      case (c)
        3'd1: begin ep[pi] = 1'b1; ep2[3 + pi] = 1'b1; d[pi] = 1'b1; end
        3'd2: ep[6 + pi] = 1'b1;
        3'd4: begin ep[9 + pi] = 1'b1; f[pi] = 1'b0; end
        3'd5: begin ep[12 + pi] = 1'b1; d[pi] = 1'b0; end
        3'd6: ep[15 + pi] = 1'b1;
        default: ;
      endcase
    end
    s = (pi < NP) ? {f[pi], st_c[pi], st_b[pi], d[pi]} : 4'b0000;
    expq.push_back(mkq(lid, 4'hA, p, s, ok, c));
    drive(mkq(lid, 4'h8, p, 4'b0, 1'b0, c), ~mkq(lid, 4'h8, p, 4'b0, 1'b0, c));
    @(posedge clk); #1;
    rx_valid = 1'b0;
    chk(acts == ep, "R3 R5 R6 action pulse", 64'(acts), 64'(ep));
    if (ok && c == 3'd1) begin
      @(posedge clk); #1;
      chk(acts == ep2, "R4 disable after notify", 64'(acts), 64'(ep2));
    end
    @(posedge clk); #1;
    chk(acts == '0 && !cf_valid, "R7 sample cycle quiet", 64'({cf_valid, acts}), 64'h0);
    @(posedge clk); #1;
    chk(cf_valid, "R7 confirmation latency", 64'(cf_valid), 64'h1);
    @(posedge clk); #1;
    chk(!cf_valid && expq.size() == 0, "R8 handshake complete",
        64'({cf_valid, 8'(expq.size())}), 64'h0);
  endtask

  task automatic drop(input logic [31:0] q0, input logic [31:0] q1, input string tag);
    drive(q0, q1);
    @(posedge clk); #1;
    rx_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(acts == '0 && !cf_valid, tag, 64'({cf_valid, acts}), 64'h0);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_q0 = '0; rx_q1 = '0; cf_ready = 1'b1;
    lid = 6'h2A;
    st_f = 3'b111; st_c = 3'b101; st_b = 3'b011; st_d = 3'b010;
    repeat (3) @(posedge clk);
    #1;
    chk(!cf_valid && acts == '0, "R8 reset state", 64'({cf_valid, acts}), 64'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk(!cf_valid && acts == '0, "R8 idle after reset", 64'({cf_valid, acts}), 64'h0);

    // R3 R7: accepted commands on distinct ports.
    send(4'd1, 3'd5);   // enable port 1: disabled bit drops
    send(4'd2, 3'd4);   // clear fault on port 2
    send(4'd0, 3'd2);   // suspend port 0
    send(4'd2, 3'd6);   // resume port 2
    // R4: notify then disable, status shows disabled
    send(4'd0, 3'd1);
    send(4'd2, 3'd1);
    // R6: no-op accepted, reserved codes rejected
    send(4'd1, 3'd0);
    send(4'd0, 3'd3);
    send(4'd1, 3'd7);
    // R5: ports out of range
    send(4'd3, 3'd5);
    send(4'd15, 3'd1);

    // R2: each drop condition alone
    drop(mkq(lid, 4'h8, 4'd0, 4'b0, 1'b0, 3'd5),
         ~mkq(lid, 4'h8, 4'd0, 4'b0, 1'b0, 3'd5) ^ 32'h0000_0100, "R2 bad complement dropped");
    drop(mkq(6'h15, 4'h8, 4'd0, 4'b0, 1'b0, 3'd4),
         ~mkq(6'h15, 4'h8, 4'd0, 4'b0, 1'b0, 3'd4), "R2 foreign node dropped");
    drop(mkq(lid, 4'hA, 4'd1, 4'b0, 1'b0, 3'd2),
         ~mkq(lid, 4'hA, 4'd1, 4'b0, 1'b0, 3'd2), "R2 wrong type dropped");
    drop(mkq(lid, 4'h0, 4'd1, 4'b0, 1'b0, 3'd6),
         ~mkq(lid, 4'h0, 4'd1, 4'b0, 1'b0, 3'd6), "R2 zero type dropped");

    // R1: a new local node number is used both for matching and as the sender
    lid = 6'h05;
    drop(mkq(6'h2A, 4'h8, 4'd0, 4'b0, 1'b0, 3'd2),
         ~mkq(6'h2A, 4'h8, 4'd0, 4'b0, 1'b0, 3'd2), "R2 old node number dropped");
    send(4'd0, 3'd5);

    // R8: hold while ready is low, ignore a packet arriving meanwhile
    begin
      logic [31:0] held;
      cf_ready = 1'b0;
      expq.push_back(mkq(lid, 4'hA, 4'd2, {st_f[2], st_c[2], st_b[2], 1'b1}, 1'b1, 3'd1));
      drive(mkq(lid, 4'h8, 4'd2, 4'b0, 1'b0, 3'd1), ~mkq(lid, 4'h8, 4'd2, 4'b0, 1'b0, 3'd1));
      @(posedge clk); #1; rx_valid = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      chk(cf_valid, "R8 confirmation pending", 64'(cf_valid), 64'h1);
      held = cf_q0;
      drive(mkq(lid, 4'h8, 4'd1, 4'b0, 1'b0, 3'd4), ~mkq(lid, 4'h8, 4'd1, 4'b0, 1'b0, 3'd4));
      @(posedge clk); #1; rx_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
        chk(acts == '0, "R8 packet ignored while pending", 64'(acts), 64'h0);
        chk(cf_valid && cf_q0 == held, "R8 confirmation held", 64'(cf_q0), 64'(held));
        @(posedge clk); #1;
      end
      cf_ready = 1'b1;
      @(posedge clk); #1;
      chk(!cf_valid, "R8 released by ready", 64'(cf_valid), 64'h0);
      for (int k = 0; k < 5; k++) begin
        chk(acts == '0 && !cf_valid, "R8 ignored packet left no trace",
            64'({cf_valid, acts}), 64'h0);
        @(posedge clk); #1;
      end
      chk(expq.size() == 0, "R8 scoreboard drained", 64'(expq.size()), 64'h0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule